// File: doc/BRIEF.md
# Block Address Translation Unit

This block translates an effective address through a small set of block-translation entries. It holds one entry array for instruction fetches and another for data accesses. Each entry has an effective base, a compare mask, a real base, a protection code and two qualifying bits, one for user mode and one for supervisor mode. A lookup picks the array named by the access side. It keeps the entries that are enabled for the current privilege mode and whose masked address equals their base, and passes over any of those whose protection does not allow writing. The lowest-numbered remaining entry supplies the real address and the permissions. When no entry remains, the unit reports a miss, and the surrounding translation logic then tries its page-table path.

Lookup requests enter through a valid/ready port and results leave through a valid/ready port. A request is taken on any clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty or is being drained in the same cycle. A result stays frozen while `rsp_valid` is high and `rsp_ready` is low, and no new request is taken during that time. Entries are loaded through a plain indexed write port, and each write replaces a whole entry.

Top module: `blk_xlate`

## Requirements
- R1: After reset every entry in both arrays is disabled, `rsp_valid` is 0, `req_ready` is 1, and any lookup reports a miss.
- R2: `req_side` = 0 searches the instruction array and `req_side` = 1 searches the data array. `wr_side` uses the same encoding to choose which array a write goes to.
- R3: When `req_user` = 1, an entry is considered only if its user-enable bit is set. When `req_user` = 0, it is considered only if its supervisor-enable bit is set.
- R4: An entry matches when `(req_ea & mask) == base`.
- R5: On a hit, `rsp_real` = `real_base | (req_ea & ~mask)` of the selected entry.
- R6: A matching entry whose protection code is 0 (no access) or 1 (read-only) is skipped, and the search continues with higher indices. Codes 2 and 3 mean read/write.
- R7: When several entries qualify, the one with the lowest index is used.
- R8: On a hit, `rsp_rd`, `rsp_wr` and `rsp_ex` are all 1. On a miss, `rsp_hit`, `rsp_real` and all three permissions are 0.
- R9: A request accepted on a clock edge gives `rsp_valid` = 1 with its result after that same edge. While `rsp_valid` = 1 and `rsp_ready` = 0, the result holds and `req_ready` is 0. `rsp_valid` falls after an edge where `rsp_ready` = 1 and no request is accepted.
- R10: A write with `wr_en` = 1 takes effect at its clock edge and applies to every request accepted on a later edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Entry write strobe |
| wr_side | input | 1 | Target array: 0 instruction, 1 data |
| wr_idx | input | IDX_W | Entry index to write |
| wr_base | input | ADDR_W | Effective base to store |
| wr_mask | input | ADDR_W | Compare mask to store |
| wr_real | input | ADDR_W | Real base to store |
| wr_prot | input | 2 | Protection code to store |
| wr_uen | input | 1 | User-mode enable bit |
| wr_sen | input | 1 | Supervisor-mode enable bit |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be taken |
| req_side | input | 1 | Access side: 0 instruction, 1 data |
| req_user | input | 1 | 1 for user mode, 0 for supervisor mode |
| req_ea | input | ADDR_W | Effective address to translate |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_hit | output | 1 | Block translation found |
| rsp_real | output | ADDR_W | Translated real address |
| rsp_rd | output | 1 | Read allowed |
| rsp_wr | output | 1 | Write allowed |
| rsp_ex | output | 1 | Execute allowed |

## Verification
A result registers on the edge that accepts its request. The bench therefore drives a request on a falling edge and reads the result on the next falling edge, one rising edge later. An entry write drives `wr_en` for one falling-to-falling window, and the bench issues any lookup that depends on it only after that window. This exercises the rule that a write counts from its own edge onward. In the stall scenario the bench keeps `rsp_ready` low across two edges and confirms each time that the earlier result and a low `req_ready` persist. It then releases `rsp_ready` and expects the waiting request's result exactly one edge later.

// File: rtl/blk_xlate_pkg.sv
package blk_xlate_pkg;

  localparam int unsigned PROT_W = 2;

  typedef enum logic {
    SIDE_INSTR = 1'b0,
    SIDE_DATA  = 1'b1
  } side_e;

  localparam logic [PROT_W-1:0] PROT_NONE = 2'd0;
  localparam logic [PROT_W-1:0] PROT_RO   = 2'd1;

  function automatic logic prot_writable(input logic [PROT_W-1:0] p);
    return p > PROT_RO;
  endfunction

  function automatic logic prot_readable(input logic [PROT_W-1:0] p);
    return p != PROT_NONE;
  endfunction

endpackage

// File: rtl/blk_xlate_bank.sv
module blk_xlate_bank
  import blk_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NENT   = 8,
  localparam int unsigned IDX_W = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [ADDR_W-1:0] wr_mask,
  input  logic [ADDR_W-1:0] wr_real,
  input  logic [PROT_W-1:0] wr_prot,
  input  logic              wr_uen,
  input  logic              wr_sen,
  output logic [ADDR_W-1:0] base_q [NENT],
  output logic [ADDR_W-1:0] mask_q [NENT],
  output logic [ADDR_W-1:0] real_q [NENT],
  output logic [PROT_W-1:0] prot_q [NENT],
  output logic [NENT-1:0]   uen_q,
  output logic [NENT-1:0]   sen_q
);

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[g] <= '0;
        mask_q[g] <= '0;
        real_q[g] <= '0;
        prot_q[g] <= PROT_NONE;
        uen_q[g]  <= 1'b0;
        sen_q[g]  <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        base_q[g] <= wr_base;
        mask_q[g] <= wr_mask;
        real_q[g] <= wr_real;
        prot_q[g] <= wr_prot;
        uen_q[g]  <= wr_uen;
        sen_q[g]  <= wr_sen;
      end
    end
  end

  // R10: a written entry shows the stored fields right after its edge
  a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (base_q[$past(wr_idx)] == $past(wr_base)) &&
              (real_q[$past(wr_idx)] == $past(wr_real)));

endmodule

// File: rtl/blk_xlate_match.sv
module blk_xlate_match
  import blk_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NENT   = 8
) (
  input  logic [ADDR_W-1:0] ea,
  input  logic              user,
  input  logic [ADDR_W-1:0] base [NENT],
  input  logic [ADDR_W-1:0] mask [NENT],
  input  logic [PROT_W-1:0] prot [NENT],
  input  logic [NENT-1:0]   uen,
  input  logic [NENT-1:0]   sen,
  output logic [NENT-1:0]   qual
);

  for (genvar g = 0; g < NENT; g++) begin : g_cmp
    logic mode_ok, addr_ok;
    assign mode_ok = user ? uen[g] : sen[g];
    assign addr_ok = (ea & mask[g]) == base[g];
    assign qual[g] = mode_ok && addr_ok && prot_writable(prot[g]);
  end

endmodule

// File: rtl/blk_xlate_pick.sv
module blk_xlate_pick #(
  parameter int unsigned NENT   = 8,
  localparam int unsigned IDX_W = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NENT-1:0]  req,
  output logic [NENT-1:0]  grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  always_comb begin
    idx = '0;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any   = |req;
  assign grant = any ? (NENT'(1) << idx) : '0;

  // R7: at most one winner, and it is one of the requesters
  a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~req) == '0));

  // R7: nothing below the winner was requesting
  a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((req & (grant - NENT'(1))) == '0));

endmodule

// File: rtl/blk_xlate.sv
module blk_xlate
  import blk_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NENT   = 8,
  localparam int unsigned IDX_W = (NENT > 1) ? $clog2(NENT) : 1,
  localparam int unsigned NSIDE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_side,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [ADDR_W-1:0] wr_mask,
  input  logic [ADDR_W-1:0] wr_real,
  input  logic [1:0]        wr_prot,
  input  logic              wr_uen,
  input  logic              wr_sen,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_side,
  input  logic              req_user,
  input  logic [ADDR_W-1:0] req_ea,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [ADDR_W-1:0] rsp_real,
  output logic              rsp_rd,
  output logic              rsp_wr,
  output logic              rsp_ex
);

  logic [ADDR_W-1:0] s_base [NSIDE][NENT];
  logic [ADDR_W-1:0] s_mask [NSIDE][NENT];
  logic [ADDR_W-1:0] s_real [NSIDE][NENT];
  logic [PROT_W-1:0] s_prot [NSIDE][NENT];
  logic [NENT-1:0]   s_uen  [NSIDE];
  logic [NENT-1:0]   s_sen  [NSIDE];

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    blk_xlate_bank #(.ADDR_W(ADDR_W), .NENT(NENT)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en && (wr_side == 1'(s))),
      .wr_idx  (wr_idx),
      .wr_base (wr_base),
      .wr_mask (wr_mask),
      .wr_real (wr_real),
      .wr_prot (wr_prot),
      .wr_uen  (wr_uen),
      .wr_sen  (wr_sen),
      .base_q  (s_base[s]),
      .mask_q  (s_mask[s]),
      .real_q  (s_real[s]),
      .prot_q  (s_prot[s]),
      .uen_q   (s_uen[s]),
      .sen_q   (s_sen[s])
    );
  end

  logic [ADDR_W-1:0] a_base [NENT];
  logic [ADDR_W-1:0] a_mask [NENT];
  logic [ADDR_W-1:0] a_real [NENT];
  logic [PROT_W-1:0] a_prot [NENT];
  logic [NENT-1:0]   a_uen, a_sen;

  always_comb begin
    for (int i = 0; i < NENT; i++) begin
      a_base[i] = s_base[req_side][i];
      a_mask[i] = s_mask[req_side][i];
      a_real[i] = s_real[req_side][i];
      a_prot[i] = s_prot[req_side][i];
    end
    a_uen = s_uen[req_side];
    a_sen = s_sen[req_side];
  end

  logic [NENT-1:0]  qual, grant;
  logic [IDX_W-1:0] win;
  logic             found;

  blk_xlate_match #(.ADDR_W(ADDR_W), .NENT(NENT)) u_match (
    .ea   (req_ea),
    .user (req_user),
    .base (a_base),
    .mask (a_mask),
    .prot (a_prot),
    .uen  (a_uen),
    .sen  (a_sen),
    .qual (qual)
  );

  blk_xlate_pick #(.NENT(NENT)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (qual),
    .grant (grant),
    .idx   (win),
    .any   (found)
  );

  logic accept;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_real  <= '0;
      rsp_rd    <= 1'b0;
      rsp_wr    <= 1'b0;
      rsp_ex    <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= found;
      rsp_real  <= found ? (a_real[win] | (req_ea & ~a_mask[win])) : '0;
      rsp_rd    <= found && prot_readable(a_prot[win]);
      rsp_wr    <= found && prot_writable(a_prot[win]);
      rsp_ex    <= found;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R9: an accepted request yields a result on the next edge
  a_r9_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R9: a stalled result does not move
  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_real) &&
                                  $stable(rsp_hit));

  // R8: hits grant every permission
  a_r8_hit_perms: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (rsp_rd && rsp_wr && rsp_ex));

  // R8: misses carry an all-zero result
  a_r8_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_real == '0) && !rsp_rd && !rsp_wr && !rsp_ex);

endmodule

// File: tb/blk_xlate_test.sv
`timescale 1ns/1ps
module blk_xlate_test;

  localparam int AW = 32;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 0, wr_side = 0, wr_uen = 0, wr_sen = 0;
  logic [IW-1:0] wr_idx = '0;
  logic [AW-1:0] wr_base = '0, wr_mask = '0, wr_real = '0;
  logic [1:0]    wr_prot = '0;
  logic          req_valid = 0, req_side = 0, req_user = 0, rsp_ready = 1;
  logic [AW-1:0] req_ea = '0;
  logic          req_ready, rsp_valid, rsp_hit, rsp_rd, rsp_wr, rsp_ex;
  logic [AW-1:0] rsp_real;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  blk_xlate uut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_side(wr_side), .wr_idx(wr_idx),
    .wr_base(wr_base), .wr_mask(wr_mask), .wr_real(wr_real),
    .wr_prot(wr_prot), .wr_uen(wr_uen), .wr_sen(wr_sen),
    .req_valid(req_valid), .req_ready(req_ready), .req_side(req_side),
    .req_user(req_user), .req_ea(req_ea),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_real(rsp_real), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ex(rsp_ex)
  );

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(input logic side, input logic [IW-1:0] idx, input logic [AW-1:0] base,
                     input logic [AW-1:0] mask, input logic [AW-1:0] rl, input logic [1:0] prot,
                     input logic uen, input logic sen);
    @(negedge clk);
    wr_en = 1; wr_side = side; wr_idx = idx; wr_base = base; wr_mask = mask;
    wr_real = rl; wr_prot = prot; wr_uen = uen; wr_sen = sen;
    @(negedge clk);
    wr_en = 0;
  endtask

  // one accepted lookup; result sampled one edge later
  task automatic look(input string tag, input logic side, input logic user, input logic [AW-1:0] ea,
                      input logic exp_hit, input logic [AW-1:0] exp_real);
    @(negedge clk);
    req_valid = 1; req_side = side; req_user = user; req_ea = ea; rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    check({tag, " valid"}, AW'(rsp_valid), AW'(1));
    check({tag, " hit"}, AW'(rsp_hit), AW'(exp_hit));
    check({tag, " real"}, rsp_real, exp_real);
    check({tag, " perms"}, AW'({rsp_rd, rsp_wr, rsp_ex}), exp_hit ? AW'(7) : AW'(0));
  endtask

  task automatic t_reset();
    check("R1 rsp_valid", AW'(rsp_valid), 0);
    check("R1 req_ready", AW'(req_ready), 1);
    look("R1 empty data", 1, 0, 32'h1234_5678, 0, 0);
    look("R1 empty instr", 0, 1, 32'h0000_0000, 0, 0);
  endtask

  task automatic t_basic();
    put(1, 2, 32'h1000_0000, 32'hF000_0000, 32'h8000_0000, 2, 1, 1);
    look("R4 R5 data hit", 1, 0, 32'h1234_5678, 1, 32'h8234_5678);
    look("R2 instr side miss", 0, 0, 32'h1234_5678, 0, 0);
    put(0, 0, 32'h1000_0000, 32'hFFF0_0000, 32'h4000_0000, 3, 1, 1);
    look("R2 R5 instr hit", 0, 0, 32'h1004_5678, 1, 32'h4004_5678);
    look("R4 mask mismatch", 0, 0, 32'h1234_5678, 0, 0);
  endtask

  task automatic t_mode();
    put(1, 5, 32'h2000_0000, 32'hF000_0000, 32'hA000_0000, 3, 1, 0);
    look("R3 supervisor skips user-only", 1, 0, 32'h2000_0010, 0, 0);
    look("R3 user takes user-only", 1, 1, 32'h2000_0010, 1, 32'hA000_0010);
    put(1, 6, 32'h6000_0000, 32'hF000_0000, 32'hB000_0000, 2, 0, 1);
    look("R3 user skips supervisor-only", 1, 1, 32'h6000_0004, 0, 0);
  endtask

  task automatic t_prot();
    put(1, 0, 32'h3000_0000, 32'hF000_0000, 32'h1000_0000, 0, 1, 1);
    put(1, 1, 32'h3000_0000, 32'hF000_0000, 32'h2000_0000, 1, 1, 1);
    put(1, 3, 32'h3000_0000, 32'hF000_0000, 32'h3000_0000, 2, 1, 1);
    put(1, 4, 32'h3000_0000, 32'hF000_0000, 32'h4000_0000, 3, 1, 1);
    look("R6 R7 skip none/ro, take 3", 1, 0, 32'h3000_0ABC, 1, 32'h3000_0ABC);
    put(1, 1, 32'h3000_0000, 32'hF000_0000, 32'h2000_0000, 2, 1, 1);
    look("R7 R10 rewritten 1 wins", 1, 0, 32'h3000_0ABC, 1, 32'h2000_0ABC);
    put(1, 1, 32'h3000_0000, 32'hF000_0000, 32'h2000_0000, 0, 1, 1);
    put(1, 3, 32'h3000_0000, 32'hF000_0000, 32'h3000_0000, 1, 1, 1);
    look("R6 falls through to 4", 1, 0, 32'h3000_0ABC, 1, 32'h4000_0ABC);
    put(1, 4, 32'h3000_0000, 32'hF000_0000, 32'h4000_0000, 1, 1, 1);
    look("R6 R8 all unwritable miss", 1, 0, 32'h3000_0ABC, 0, 0);
  endtask

  task automatic t_stall();
    @(negedge clk);
    req_valid = 1; req_side = 1; req_user = 0; req_ea = 32'h1234_5678; rsp_ready = 0;
    @(negedge clk);
    check("R9 first result", rsp_real, 32'h8234_5678);
    req_ea = 32'h1000_0001;
    @(negedge clk);
    check("R9 held valid", AW'(rsp_valid), 1);
    check("R9 held real", rsp_real, 32'h8234_5678);
    check("R9 not ready", AW'(req_ready), 0);
    @(negedge clk);
    check("R9 still held", rsp_real, 32'h8234_5678);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    check("R9 waiting request served", rsp_real, 32'h8000_0001);
    check("R9 valid after release", AW'(rsp_valid), 1);
    @(negedge clk);
    check("R9 drained", AW'(rsp_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_mode();
    t_prot();
    t_stall();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule